// File: doc/BRIEF.md
# Multiplexed-Carry Ripple Adder with Signed Overflow

This block adds two two's-complement operands of parameterised width and an incoming carry. It produces the sum, the carry leaving the top bit and a flag for signed overflow. It is purely combinational and is meant to sit between registers owned by the surrounding logic.

The carry path is a ripple chain of identical cells, and every cell is written out bit by bit. Each cell XORs its two operand bits into a propagate term. A 2:1 selector then forwards either the incoming carry (when propagate is high) or the cell's second operand bit (when propagate is low, where both operand bits are equal and so equal the carry). The sum bit is the propagate term XORed with the incoming carry.

Overflow is taken from the two highest carries of the chain: the carry into the most significant cell and the carry out of it. The longest path runs from the lowest cell through every intermediate selector to the top, so delay grows linearly with width.

Top module: `mux_carry_adder`

## Requirements
- R1: `sum_o` equals the low WIDTH bits of the unsigned value `a_i + b_i + cin_i`, for every operand pair and both carry-in values.
- R2: `cout_o` equals bit WIDTH (the bit just above the sum) of the unsigned value `a_i + b_i + cin_i`.
- R3: In every cell the outgoing carry is the incoming carry when the two operand bits differ, and the second operand bit when they match. So when `a_i == b_i`, `cout_o` equals `b_i[WIDTH-1]` and `sum_o` equals `{b_i[WIDTH-2:0], cin_i}`.
- R4: `ovf_o` is 1 exactly when both operands have the same sign bit and `sum_o` has the opposite sign bit.
- R5: `ovf_o` equals the carry into the top cell XOR `cout_o`. Largest positive + 1 gives overflow with `cout_o`=0; most negative + most negative gives overflow with `cout_o`=1; -1 + 1 gives no overflow with `cout_o`=1.
- R6: `cin_i` enters the lowest cell. With `a_i` all ones and `b_i` zero, the carry ripples through the whole chain: `cout_o == cin_i` and `sum_o` is all ones when `cin_i`=0 and all zeros when `cin_i`=1.
- R7: The same behaviour holds for any WIDTH of 2 or more; the bench exercises both WIDTH=6 and WIDTH=16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand, two's complement |
| b_i | input | WIDTH | Second operand; also the carry source in cells where the operand bits match |
| cin_i | input | 1 | Carry into the lowest cell |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of the top cell |
| ovf_o | output | 1 | Signed overflow flag |

## Verification
Immediate assertions are re-evaluated whenever their inputs change. In every cell they check that the outgoing carry and sum bit encode the count of ones among the three cell inputs, which is the majority-and-parity view of the selector structure. At the top they check the sign rule for overflow and the full-length ripple from carry-in to carry-out. Whole-word correctness of sum and carry, and the word-level boundary values of overflow, are shown only by the bench. The bench sweeps every operand pair and carry-in at WIDTH=6 and applies random vectors and corner values at WIDTH=16.

// File: rtl/mca_pkg.sv
package mca_pkg;
  // Default operand width; small enough for an exhaustive sweep.
  localparam int unsigned DEFAULT_WIDTH = 6;
  // Smallest width for which a top cell and a carry below it both exist.
  localparam int unsigned MIN_WIDTH = 2;
endpackage

// File: rtl/mca_cell.sv
// One fast-carry cell: propagate term, carry selector, sum XOR.
module mca_cell (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic c_o,
  output logic s_o
);
  logic prop;

  always_comb begin
    prop = x_i ^ y_i;
    // Operands equal -> y_i is the carry; operands differ -> pass c_i.
    c_o  = prop ? c_i : y_i;
    s_o  = prop ^ c_i;
  end

  always_comb begin
    AST_CELL_MAJORITY: assert (c_o == ((x_i & y_i) | (x_i & c_i) | (y_i & c_i))) // R3
      else $error("cell carry is not the majority of its inputs");
    AST_CELL_COUNT: assert ({c_o, s_o} == (2'(x_i) + 2'(y_i) + 2'(c_i))) // R1
      else $error("cell carry/sum do not encode the input count");
  end
endmodule

// File: rtl/mca_chain.sv
// Ripple chain of WIDTH cells; exposes the top two carries.
module mca_chain #(
  parameter int unsigned WIDTH = mca_pkg::DEFAULT_WIDTH
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] s_o,
  output logic             c_top_o,
  output logic             c_msb_in_o
);
  localparam int unsigned TOP = WIDTH - 1;

  logic [WIDTH:0] carry;

  assign carry[0] = c_i;

  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_cell
    mca_cell u_cell (
      .x_i (x_i[gi]),
      .y_i (y_i[gi]),
      .c_i (carry[gi]),
      .c_o (carry[gi+1]),
      .s_o (s_o[gi])
    );
  end

  assign c_top_o    = carry[WIDTH];
  assign c_msb_in_o = carry[TOP];
endmodule

// File: rtl/mca_overflow.sv
// Signed overflow from the carries around the most significant cell.
module mca_overflow (
  input  logic c_top_i,
  input  logic c_msb_in_i,
  output logic ovf_o
);
  always_comb ovf_o = c_top_i ^ c_msb_in_i;
endmodule

// File: rtl/mux_carry_adder.sv
module mux_carry_adder #(
  parameter int unsigned WIDTH = mca_pkg::DEFAULT_WIDTH
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic c_top;
  logic c_msb_in;

  if (WIDTH < mca_pkg::MIN_WIDTH) begin : g_bad_width
    initial $error("WIDTH must be at least 2");
  end

  mca_chain #(.WIDTH(WIDTH)) u_chain (
    .x_i        (a_i),
    .y_i        (b_i),
    .c_i        (cin_i),
    .s_o        (sum_o),
    .c_top_o    (c_top),
    .c_msb_in_o (c_msb_in)
  );

  mca_overflow u_ovf (
    .c_top_i    (c_top),
    .c_msb_in_i (c_msb_in),
    .ovf_o      (ovf_o)
  );

  assign cout_o = c_top;

  always_comb begin
    AST_OVERFLOW_SIGN: assert (ovf_o == ((a_i[MSB] == b_i[MSB]) && (sum_o[MSB] != a_i[MSB]))) // R4
      else $error("overflow flag disagrees with the sign rule");
    AST_FULL_RIPPLE: assert (!((&a_i) && (b_i == '0)) || (cout_o == cin_i && sum_o == {WIDTH{!cin_i}})) // R6
      else $error("carry-in did not ripple through the full chain");
  end
endmodule

// File: tb/sim_mux_carry_adder.sv
`timescale 1ns/1ps
module sim_mux_carry_adder;
  localparam int W0 = 6;
  localparam int W1 = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [W0-1:0] a0, b0, s0;
  logic          ci0, co0, ov0;
  logic [W1-1:0] a1, b1, s1;
  logic          ci1, co1, ov1;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  mux_carry_adder #(.WIDTH(W0)) u0 (
    .a_i(a0), .b_i(b0), .cin_i(ci0), .sum_o(s0), .cout_o(co0), .ovf_o(ov0));
  mux_carry_adder #(.WIDTH(W1)) u1 (
    .a_i(a1), .b_i(b1), .cin_i(ci1), .sum_o(s1), .cout_o(co1), .ovf_o(ov1));

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (a0=%0h b0=%0h a1=%0h b1=%0h)",
               req, what, act, exp, a0, b0, a1, b1);
    end
  endtask

  // Reference for WIDTH=6, integer arithmetic only.
  task automatic run0(input int a, input int b, input int c, input string tag);
    int u, sa, sb, ss;
    @(negedge clk);
    a0 = W0'(a); b0 = W0'(b); ci0 = c[0];
    #1;
    u  = (a & 63) + (b & 63) + (c & 1);
    sa = (a & 32) != 0 ? (a & 63) - 64 : (a & 63);
    sb = (b & 32) != 0 ? (b & 63) - 64 : (b & 63);
    ss = sa + sb + (c & 1);
    chk({tag, " R1"}, "sum",  longint'(s0),  longint'(u & 63));
    chk({tag, " R2"}, "cout", longint'(co0), longint'((u >> 6) & 1));
    chk({tag, " R4"}, "ovf",  longint'(ov0), longint'((ss > 31 || ss < -32) ? 1 : 0));
  endtask

  task automatic run1(input int a, input int b, input int c, input string tag);
    longint u, sa, sb, ss;
    @(negedge clk);
    a1 = W1'(a); b1 = W1'(b); ci1 = c[0];
    #1;
    u  = longint'(a & 65535) + longint'(b & 65535) + longint'(c & 1);
    sa = (a & 32768) != 0 ? longint'(a & 65535) - 65536 : longint'(a & 65535);
    sb = (b & 32768) != 0 ? longint'(b & 65535) - 65536 : longint'(b & 65535);
    ss = sa + sb + longint'(c & 1);
    chk({tag, " R7 R1"}, "sum",  longint'(s1),  u & 65535);
    chk({tag, " R7 R2"}, "cout", longint'(co1), (u >> 16) & 1);
    chk({tag, " R7 R4"}, "ovf",  longint'(ov1), (ss > 32767 || ss < -32768) ? 1 : 0);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    a0 = '0; b0 = '0; ci0 = 1'b0;
    a1 = '0; b1 = '0; ci1 = 1'b0;
    #1;
    chk("R1", "zero inputs sum", longint'(s0), 0);
    chk("R2", "zero inputs cout", longint'(co0), 0);

    // Exhaustive sweep at WIDTH=6: R1, R2, R4
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < 64; a++)
        for (int b = 0; b < 64; b++)
          run0(a, b, c, "sweep");

    // R3: equal operands -> carry comes from b, sum is b shifted up with cin
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < 64; a++) begin
        run0(a, a, c, "equal");
        chk("R3", "equal cout", longint'(co0), longint'((a >> 5) & 1));
        chk("R3", "equal sum",  longint'(s0),  longint'(((a << 1) | c) & 63));
      end

    // R5 boundaries
    run0(31, 1, 0, "bnd");
    chk("R5", "maxpos+1 ovf",  longint'(ov0), 1);
    chk("R5", "maxpos+1 cout", longint'(co0), 0);
    run0(32, 32, 0, "bnd");
    chk("R5", "minneg*2 ovf",  longint'(ov0), 1);
    chk("R5", "minneg*2 cout", longint'(co0), 1);
    run0(63, 1, 0, "bnd");
    chk("R5", "-1+1 ovf",  longint'(ov0), 0);
    chk("R5", "-1+1 cout", longint'(co0), 1);

    // R6 full ripple from carry-in
    run0(63, 0, 1, "ripple");
    chk("R6", "ripple cin=1 sum",  longint'(s0),  0);
    chk("R6", "ripple cin=1 cout", longint'(co0), 1);
    run0(63, 0, 0, "ripple");
    chk("R6", "ripple cin=0 sum",  longint'(s0),  63);
    chk("R6", "ripple cin=0 cout", longint'(co0), 0);

    // R7 wider instance: corners then random
    run1(65535, 0, 1, "wide");
    chk("R7 R6", "wide ripple sum", longint'(s1), 0);
    run1(32767, 1, 0, "wide");
    chk("R7 R5", "wide maxpos+1 ovf", longint'(ov1), 1);
    run1(32768, 32768, 0, "wide");
    chk("R7 R5", "wide minneg*2 ovf", longint'(ov1), 1);
    for (int n = 0; n < 3000; n++)
      run1(int'($urandom & 32'hFFFF), int'($urandom & 32'hFFFF), int'($urandom & 1), "rand");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule